// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a host processor. It keeps three 8-bit registers: pending requests, levels in service, and a mask. A priority resolver picks the most urgent unmasked request. The interrupt output is raised when that request outranks every level that is already in service. The host answers with two acknowledge pulses. The first pulse moves the winning request into service. The second pulse returns an 8-bit vector made of programmed upper bits and the 3-bit level number.

The host programs the block with a one-bit address, a write strobe and a read strobe. A short initialization sequence sets the trigger style, the vector base and, optionally, automatic end-of-interrupt. After that, operation commands control masking, end-of-interrupt (specific or non-specific), priority rotation, which register a status read returns, and polling. A poll read can take the place of the acknowledge pulses. Requests can be edge or level triggered. Priority can be fixed or rotating. All inputs are sampled on the rising clock edge. The read data and the vector byte are combinational from the registered state and the strobes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset and before initialization, the interrupt output stays low whatever the request inputs do, and the data bus reads 0 when no read or acknowledge is active.
- R2: A write with addr=0 and data bit 4 set starts initialization. It clears mask, in-service and request state, makes level 7 the lowest priority, and points status reads at the request register. Data bit 3 selects level triggering. Data bit 0 asks for an option word. The next addr=1 write stores the vector base from data bits 7:3.
- R3: When the option word was requested, the following addr=1 write is taken as options, and its data bit 1 enables automatic end-of-interrupt.
- R4: With edge triggering, a request is latched only on a low-to-high input transition, and is dropped if the input falls before it is acknowledged. An input already high when initialization starts does not request service.
- R5: With level triggering, a high input alone requests service, and it requests again after its end-of-interrupt if it is still high.
- R6: By default, level 0 has the highest priority and level 7 the lowest. The interrupt output is high only while the best unmasked pending request has strictly higher priority than every in-service level.
- R7: After initialization, a write with addr=1 loads the mask register, and a set mask bit keeps its request from being selected. A read with addr=1 returns the mask.
- R8: On the first acknowledge pulse, the winning request's in-service bit is set, its request bit is cleared, and the bus reads 0. The second pulse drives {base[7:3], level}. If nothing is pending at the first pulse, the second pulse drives level 7 and no in-service bit is set.
- R9: An operation write (addr=0, data bits 4:3 = 00) with bits 7:5 = 001 clears the highest-priority in-service bit. Bits 7:5 = 011 clear the level in bits 2:0.
- R10: With automatic end-of-interrupt, the highest-priority in-service bit is cleared at the end of the second acknowledge pulse.
- R11: Rotation codes in bits 7:5: 101 clears the highest in-service level and makes it the lowest priority. 111 clears level bits 2:0 and makes it the lowest. 110 makes level bits 2:0 the lowest. 100 and 000 turn rotate-on-automatic-end-of-interrupt on and off.
- R12: A write with addr=0 and data bits 4:3 = 01 is a read-control command. If bit 1 is set, bit 0 selects ISR (1) or IRR (0) for addr=0 reads. Bit 2 arms a poll. The next addr=0 read then returns {pending, 0000, level} and acts as a first acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| rd_en_i | input | 1 | Host read strobe, one cycle per read |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Host write data |
| irq_i | input | 8 | Interrupt request lines, bit n is level n |
| ack_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| bus_dout_o | output | 8 | Read data or vector byte |
| int_o | output | 1 | Interrupt to the host |

## Verification
The hardest state to reach is a rotated priority order stacked on a partly filled in-service register. In that state a pending request must stay blocked by a level that is serviced earlier in the rotated order, and must be released exactly when the rotating end-of-interrupt moves the bottom. The stimulus builds this step by step. It sets a bottom level, acknowledges one of two pending requests, and then issues the rotating and specific-rotating end-of-interrupt codes. After each step it checks which vector comes out next. Automatic rotation is reached the same way, by re-initializing with the option word and acknowledging two requests that sit on either side of the new bottom.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned LVL_N  = 8;
    localparam int unsigned LVL_W  = $clog2(LVL_N);
    localparam int unsigned DATA_W = 8;
    localparam int unsigned BASE_W = DATA_W - LVL_W;

    typedef enum logic [1:0] {
        CFG_WAIT_INIT,
        CFG_WAIT_BASE,
        CFG_WAIT_OPT,
        CFG_RUN
    } cfg_state_e;

    typedef struct packed {
        cfg_state_e         cfg;
        logic               needs_opt;
        logic               level_mode;
        logic               auto_eoi;
        logic               rot_aeoi;
        logic [BASE_W-1:0]  base;
        logic [LVL_N-1:0]   imr;
        logic [LVL_N-1:0]   isr;
        logic [LVL_W-1:0]   bottom;
        logic               read_isr;
        logic               poll_arm;
        logic               ack_second;
        logic [LVL_W-1:0]   ack_lvl;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        cfg:        CFG_WAIT_INIT,
        needs_opt:  1'b0,
        level_mode: 1'b0,
        auto_eoi:   1'b0,
        rot_aeoi:   1'b0,
        base:       '0,
        imr:        '0,
        isr:        '0,
        bottom:     LVL_W'(LVL_N - 1),
        read_isr:   1'b0,
        poll_arm:   1'b0,
        ack_second: 1'b0,
        ack_lvl:    '0
    };
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N = 8,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] bottom_i,
    output logic         hit_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rank_o
);
    // Scan starts one above the bottom level and wraps; rank 0 is most urgent.
    always_comb begin
        logic [W-1:0] idx;
        hit_o  = 1'b0;
        lvl_o  = '0;
        rank_o = '0;
        for (int i = 0; i < N; i++) begin
            idx = bottom_i + W'(i + 1);
            if (!hit_o && vec_i[idx]) begin
                hit_o  = 1'b1;
                lvl_o  = idx;
                rank_o = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic         level_mode_i,
    input  logic [N-1:0] clr_i,
    input  logic         reinit_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] irr_d, irr_q;
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = irq_i;
        if (reinit_i) begin
            irr_d  = '0;
            prev_d = '1;   // a line already high needs a fresh rising edge
        end else if (level_mode_i) begin
            irr_d = irq_i & ~clr_i;
        end else begin
            irr_d = ((irr_q & ~clr_i) | ~prev_q) & irq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q  <= '0;
            prev_q <= '1;
        end else begin
            irr_q  <= irr_d;
            prev_q <= prev_d;
        end
    end

    assign irr_o = irr_q;

    // R4/R5: no request survives a cycle in which its line was low
    assert_low_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr_q & ~$past(irq_i)) == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LVL_N-1:0]  irq_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              int_o
);
    ctl_t ctl_d, ctl_q;

    logic [LVL_N-1:0] irr;
    logic [LVL_N-1:0] irr_clr;
    logic [LVL_N-1:0] isr_set, isr_clr;
    logic             reinit;

    logic             req_hit, isr_hit;
    logic [LVL_W-1:0] req_lvl, isr_lvl, req_rank, isr_rank;
    logic             req_pend;

    logic             is_init, is_ocw2, is_ocw3, is_hi_wr;
    logic [2:0]       eoi_code;
    logic [LVL_W-1:0] cmd_lvl;

    irq_req_capture #(.N(LVL_N)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq_i),
        .level_mode_i (ctl_q.level_mode),
        .clr_i        (irr_clr),
        .reinit_i     (reinit),
        .irr_o        (irr)
    );

    irq_prio_pick #(.N(LVL_N), .W(LVL_W)) u_req_pick (
        .vec_i    (irr & ~ctl_q.imr),
        .bottom_i (ctl_q.bottom),
        .hit_o    (req_hit),
        .lvl_o    (req_lvl),
        .rank_o   (req_rank)
    );

    irq_prio_pick #(.N(LVL_N), .W(LVL_W)) u_isr_pick (
        .vec_i    (ctl_q.isr),
        .bottom_i (ctl_q.bottom),
        .hit_o    (isr_hit),
        .lvl_o    (isr_lvl),
        .rank_o   (isr_rank)
    );

    assign req_pend = (ctl_q.cfg == CFG_RUN) && req_hit && (!isr_hit || (req_rank < isr_rank));
    assign int_o    = req_pend;

    assign is_init  = wr_en_i && !addr_i && wdata_i[4];
    assign is_ocw2  = wr_en_i && !addr_i && !wdata_i[4] && !wdata_i[3] && (ctl_q.cfg == CFG_RUN);
    assign is_ocw3  = wr_en_i && !addr_i && !wdata_i[4] &&  wdata_i[3] && (ctl_q.cfg == CFG_RUN);
    assign is_hi_wr = wr_en_i && addr_i;
    assign eoi_code = wdata_i[7:5];
    assign cmd_lvl  = wdata_i[LVL_W-1:0];

    always_comb begin
        ctl_d   = ctl_q;
        isr_set = '0;
        isr_clr = '0;
        irr_clr = '0;
        reinit  = 1'b0;

        if (is_hi_wr) begin
            unique case (ctl_q.cfg)
                CFG_WAIT_BASE: begin
                    ctl_d.base = wdata_i[DATA_W-1:LVL_W];
                    ctl_d.cfg  = ctl_q.needs_opt ? CFG_WAIT_OPT : CFG_RUN;
                end
                CFG_WAIT_OPT: begin
                    ctl_d.auto_eoi = wdata_i[1];
                    ctl_d.cfg      = CFG_RUN;
                end
                CFG_RUN:       ctl_d.imr = wdata_i;
                default:       ;
            endcase
        end

        if (is_ocw2) begin
            unique case (eoi_code)
                3'b001: if (isr_hit) isr_clr[isr_lvl] = 1'b1;
                3'b101: if (isr_hit) begin
                    isr_clr[isr_lvl] = 1'b1;
                    ctl_d.bottom     = isr_lvl;
                end
                3'b011: isr_clr[cmd_lvl] = 1'b1;
                3'b111: begin
                    isr_clr[cmd_lvl] = 1'b1;
                    ctl_d.bottom     = cmd_lvl;
                end
                3'b110: ctl_d.bottom   = cmd_lvl;
                3'b100: ctl_d.rot_aeoi = 1'b1;
                3'b000: ctl_d.rot_aeoi = 1'b0;
                default: ;
            endcase
        end

        if (is_ocw3) begin
            if (wdata_i[1]) ctl_d.read_isr = wdata_i[0];
            ctl_d.poll_arm = wdata_i[2];
        end

        if (ack_i) begin
            if (!ctl_q.ack_second) begin
                ctl_d.ack_second = 1'b1;
                if (req_pend) begin
                    isr_set[req_lvl] = 1'b1;
                    irr_clr[req_lvl] = 1'b1;
                    ctl_d.ack_lvl    = req_lvl;
                end else begin
                    ctl_d.ack_lvl    = LVL_W'(LVL_N - 1);
                end
            end else begin
                ctl_d.ack_second = 1'b0;
                if (ctl_q.auto_eoi && isr_hit) begin
                    isr_clr[isr_lvl] = 1'b1;
                    if (ctl_q.rot_aeoi) ctl_d.bottom = isr_lvl;
                end
            end
        end

        if (rd_en_i) begin
            ctl_d.poll_arm = 1'b0;
            if (ctl_q.poll_arm && !addr_i && req_pend) begin
                isr_set[req_lvl] = 1'b1;
                irr_clr[req_lvl] = 1'b1;
            end
        end

        ctl_d.isr = (ctl_q.isr & ~isr_clr) | isr_set;

        if (is_init) begin
            reinit           = 1'b1;
            ctl_d            = CTL_RST;
            ctl_d.cfg        = CFG_WAIT_BASE;
            ctl_d.needs_opt  = wdata_i[0];
            ctl_d.level_mode = wdata_i[3];
            ctl_d.base       = ctl_q.base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_dout_o = '0;
        if (rd_en_i) begin
            if (addr_i)                 bus_dout_o = ctl_q.imr;
            else if (ctl_q.poll_arm)    bus_dout_o = {req_pend, 4'b0000, req_pend ? req_lvl : LVL_W'(0)};
            else if (ctl_q.read_isr)    bus_dout_o = ctl_q.isr;
            else                        bus_dout_o = irr;
        end else if (ack_i && ctl_q.ack_second) begin
            bus_dout_o = {ctl_q.base, ctl_q.ack_lvl};
        end
    end

    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_init |=> (ctl_q.imr == '0 && ctl_q.isr == '0 && ctl_q.bottom == LVL_W'(LVL_N - 1) && !int_o));

    assert_first_ack_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ctl_q.ack_second && int_o && !wr_en_i) |=> ctl_q.isr[$past(req_lvl)]);

    assert_nonspec_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ocw2 && eoi_code == 3'b001 && isr_hit && !ack_i && !rd_en_i) |=> !ctl_q.isr[$past(isr_lvl)]);

    assert_auto_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ctl_q.ack_second && ctl_q.auto_eoi && ctl_q.isr != '0 && !wr_en_i && !rd_en_i)
        |=> ($countones(ctl_q.isr) < $countones($past(ctl_q.isr))));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq = '0;
    logic [7:0] dout;
    logic       int_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .irq_i(irq), .ack_i(ack), .bus_dout_o(dout), .int_o(int_out)
    );

    // pattern, mask, expect int, expect level
    localparam logic [19:0] VEC_TBL [6] = '{
        {8'h01, 8'h00, 1'b1, 3'd0},
        {8'hA0, 8'h00, 1'b1, 3'd5},
        {8'hF0, 8'h30, 1'b1, 3'd6},
        {8'h80, 8'h80, 1'b0, 3'd0},
        {8'h44, 8'h00, 1'b1, 3'd2},
        {8'hFF, 8'hFE, 1'b1, 3'd0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 v = dout;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ackp(output logic [7:0] v);
        @(negedge clk); ack = 1'b1; #1 v = dout;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic chk_int(input string req, input logic exp);
        #1 check(req, {7'b0, int_out}, {7'b0, exp});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        irq = 8'h08;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk_int("R1 uninit int", 1'b0);
        check("R1 idle bus", dout, 8'h00);

        // init: edge, no option word, base 0x40
        wr(0, 8'h10); wr(1, 8'h40);
        cyc(); chk_int("R4 held-high ignored", 1'b0);
        irq = 8'h00; cyc(); irq = 8'h08; cyc();
        chk_int("R4 rising edge requests", 1'b1);
        irq = 8'h00; cyc();
        chk_int("R4 falling drops request", 1'b0);
        irq = 8'h20; cyc();
        rd(0, v); check("R2 status reads IRR", v, 8'h20);
        irq = 8'h00; cyc();

        // table walk: R6 priority, R7 masking, R8 vector
        for (int i = 0; i < 6; i++) begin
            logic [7:0] pat, msk; logic ei; logic [2:0] el;
            {pat, msk, ei, el} = VEC_TBL[i];
            wr(1, msk);
            irq = pat; cyc();
            chk_int("R6/R7 int_o for pattern", ei);
            if (ei) begin
                ackp(v); check("R8 first pulse bus", v, 8'h00);
                ackp(v); check("R8/R6 vector", v, {5'b01000, el});
            end
            irq = 8'h00; cyc();
            if (ei) wr(0, 8'h20);
            wr(1, 8'h00);
        end

        wr(1, 8'h5A); rd(1, v); check("R7 mask readback", v, 8'h5A);
        wr(1, 8'h00);

        // spurious acknowledge
        ackp(v); ackp(v); check("R8 spurious vector", v, 8'h47);
        wr(0, 8'h0B); rd(0, v); check("R8 spurious no ISR", v, 8'h00);
        wr(0, 8'h0A);

        // nesting and EOI
        irq = 8'h10; cyc(); ackp(v); ackp(v); check("R8 vector lvl4", v, 8'h44);
        irq = 8'h50; cyc(); chk_int("R6 lower blocked", 1'b0);
        irq = 8'h52; cyc(); chk_int("R6 higher nests", 1'b1);
        ackp(v); ackp(v); check("R6 nested vector", v, 8'h41);
        wr(0, 8'h0B); rd(0, v); check("R12 ISR read", v, 8'h12);
        wr(0, 8'h20); rd(0, v); check("R9 nonspecific EOI", v, 8'h10);
        chk_int("R6 lvl6 still blocked", 1'b0);
        wr(0, 8'h64); rd(0, v); check("R9 specific EOI", v, 8'h00);
        chk_int("R6 lvl6 released", 1'b1);
        ackp(v); ackp(v); check("R8 vector lvl6", v, 8'h46);
        wr(0, 8'h20); irq = 8'h00; cyc();
        wr(0, 8'h0A);

        // rotation
        wr(0, 8'hC3);
        irq = 8'h24; cyc();
        ackp(v); ackp(v); check("R11 set bottom 3 picks 5", v, 8'h45);
        chk_int("R11 lvl2 below 5", 1'b0);
        wr(0, 8'hA0);
        chk_int("R11 rotate EOI frees 2", 1'b1);
        ackp(v); ackp(v); check("R11 after rotate picks 2", v, 8'h42);
        wr(0, 8'hE2);
        irq = 8'h00; cyc(); irq = 8'h0A; cyc();
        ackp(v); ackp(v); check("R11 specific rotate picks 3", v, 8'h43);
        wr(0, 8'h20);
        ackp(v); ackp(v); check("R11 then picks 1", v, 8'h41);
        wr(0, 8'h20); irq = 8'h00; cyc();

        // auto EOI with option word
        wr(0, 8'h11); wr(1, 8'h80); wr(1, 8'h02);
        irq = 8'h01; cyc();
        ackp(v); ackp(v); check("R3 vector new base", v, 8'h80);
        wr(0, 8'h0B); rd(0, v); check("R10 auto EOI clears ISR", v, 8'h00);
        wr(0, 8'h80);
        irq = 8'h00; cyc(); irq = 8'h01; cyc();
        ackp(v); ackp(v); check("R10 vector lvl0", v, 8'h80);
        irq = 8'h00; cyc(); irq = 8'h81; cyc();
        ackp(v); ackp(v); check("R11 auto rotate bottom 0", v, 8'h87);
        ackp(v); ackp(v); check("R11 lvl0 now last", v, 8'h80);
        irq = 8'h00; cyc();

        // level trigger and poll
        wr(0, 8'h18); wr(1, 8'h20);
        irq = 8'h40; cyc(); chk_int("R5 level requests", 1'b1);
        ackp(v); ackp(v); check("R5 level vector", v, 8'h26);
        chk_int("R5 in service", 1'b0);
        wr(0, 8'h20); chk_int("R5 re-request after EOI", 1'b1);
        wr(0, 8'h0C); rd(0, v); check("R12 poll word", v, 8'h86);
        chk_int("R12 poll took service", 1'b0);
        wr(0, 8'h0B); rd(0, v); check("R12 poll set ISR", v, 8'h40);
        wr(0, 8'h20); irq = 8'h00; cyc(); cyc();
        chk_int("R5 level drop", 1'b0);
        wr(0, 8'h0C); rd(0, v); check("R12 poll empty", v, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule